// File: doc/BRIEF.md
# Cache Allocation Policy Filter

This block sits on the path between first-level miss handling and a second-level cache controller. Each request carries its class (instruction fetch or data), its direction (read or write), the second-level lookup result (hit or miss) and a tag. For each accepted request the filter decides one of three outcomes:

- serve the access from the second-level cache;
- serve it there and also allocate a new line;
- send it around the cache as a cache-inhibited access.

It returns that decision one cycle later together with the request tag and direction.

Two policy bits steer the decision, and software may rewrite them at any moment:

- **Restrict-to-instructions** stops data misses from entering the cache.
- **Restrict-to-data** stops instruction misses from entering it.
- **Both bits set** lock the cache. No miss of either class allocates, but every hit, writes included, is still served by the cache.

The policy bits are sampled in the cycle a request is accepted. A change therefore affects later requests and never a response that is already held.

The output is a single registered stage with a valid/ready handshake. Reset is asserted asynchronously (active low) and released synchronously inside the block.

Top module: `pf_alloc_filter`

## Requirements
- R1: A request accepted with `req_l2_hit`=1 produces a response with `rsp_use_l2`=1, `rsp_allocate`=0 and `rsp_bypass`=0. This holds for reads and writes, for both classes, under every policy setting.
- R2: With `mode_instr_only`=1 and `mode_data_only`=0, a data request (`req_is_instr`=0) that misses (`req_l2_hit`=0) produces `rsp_bypass`=1, `rsp_use_l2`=0 and `rsp_allocate`=0.
- R3: With `mode_data_only`=1 and `mode_instr_only`=0, an instruction request (`req_is_instr`=1) that misses produces `rsp_bypass`=1, `rsp_use_l2`=0 and `rsp_allocate`=0.
- R4: With both policy bits set, every miss produces `rsp_bypass`=1 and `rsp_allocate`=0, while hits, including write hits (`req_is_write`=1), still give `rsp_use_l2`=1.
- R5: A miss whose class is not restricted by the current policy bits produces `rsp_use_l2`=1 and `rsp_allocate`=1. With both bits clear, every miss is such a miss.
- R6: Every valid response has exactly one of `rsp_use_l2` and `rsp_bypass` set, and `rsp_allocate`=1 only together with `rsp_use_l2`=1.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) appears as `rsp_valid`=1 after that edge, carrying the same `req_tag` and `req_is_write`.
- R8: `req_ready` equals `!rsp_valid || rsp_ready` once out of reset. While `rsp_valid`=1 and `rsp_ready`=0, the response and all its fields hold steady.
- R9: The policy bits are sampled only at acceptance. Changing them while a response is held leaves that response unchanged, and the next accepted request uses the new setting.
- R10: After reset `rsp_valid`=0 and no request is accepted until the internal reset release completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_instr_only | input | 1 | Keep data misses out of the cache |
| mode_data_only | input | 1 | Keep instruction misses out of the cache |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_is_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_l2_hit | input | 1 | 1 = second-level lookup hit, 0 = miss |
| req_tag | input | TAG_W | Request identifier |
| rsp_valid | output | 1 | Decision present |
| rsp_ready | input | 1 | Downstream takes the decision |
| rsp_use_l2 | output | 1 | Access is served by the cache |
| rsp_allocate | output | 1 | Allocate a new line for this miss |
| rsp_bypass | output | 1 | Access goes around the cache, cache-inhibited |
| rsp_write | output | 1 | Direction of the request |
| rsp_tag | output | TAG_W | Tag of the request |

## Verification
The assertions assume that the policy bits and the request fields are settled in the cycle of acceptance and that `rsp_ready` is a plain level supplied by the consumer. They also take the hit flag as given, because the block cannot judge whether a lookup result is true. The bench changes every input only on the falling clock edge, so each value is stable across the rising edge that samples it. Stimulus mixes random requests and random back-pressure with directed sweeps of all policy settings, and also includes policy changes made while a response is stalled.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Policy setting as seen by the decision logic: {data_only, instr_only}
  typedef enum logic [1:0] {
    PF_POL_OPEN   = 2'b00,
    PF_POL_INSTR  = 2'b01,
    PF_POL_DATA   = 2'b10,
    PF_POL_LOCKED = 2'b11
  } pf_policy_e;

  typedef struct packed {
    logic use_l2;
    logic allocate;
    logic bypass;
  } pf_action_t;

  localparam int PF_ACTION_W = $bits(pf_action_t);

endpackage

// File: rtl/pf_reset_sync.sv
module pf_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pf_decide.sv
module pf_decide
  import pf_pkg::*;
(
  input  logic       is_instr,
  input  logic       l2_hit,
  input  pf_policy_e policy,
  output pf_action_t action
);
  logic class_blocked;

  always_comb begin
    unique case (policy)
      PF_POL_OPEN:   class_blocked = 1'b0;
      PF_POL_INSTR:  class_blocked = !is_instr;
      PF_POL_DATA:   class_blocked = is_instr;
      PF_POL_LOCKED: class_blocked = 1'b1;
      default:       class_blocked = 1'b1;
    endcase
  end

  always_comb begin
    action = '0;
    if (l2_hit) begin
      action.use_l2 = 1'b1;
    end else if (class_blocked) begin
      action.bypass = 1'b1;
    end else begin
      action.use_l2   = 1'b1;
      action.allocate = 1'b1;
    end
  end
endmodule

// File: rtl/pf_pipe_stage.sv
module pf_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         valid_q;
  logic         valid_d;
  logic         load;
  logic [W-1:0] data_q;

  assign in_ready = run && (!valid_q || out_ready);
  assign load     = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= in_data;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/pf_alloc_filter.sv
module pf_alloc_filter
  import pf_pkg::*;
#(
  parameter int TAG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_instr_only,
  input  logic             mode_data_only,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_instr,
  input  logic             req_is_write,
  input  logic             req_l2_hit,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_use_l2,
  output logic             rsp_allocate,
  output logic             rsp_bypass,
  output logic             rsp_write,
  output logic [TAG_W-1:0] rsp_tag
);
  localparam int PAY_W = TAG_W + 1 + PF_ACTION_W;

  logic       rst_sync_n;
  pf_policy_e policy;
  pf_action_t action_d;
  pf_action_t action_q;
  logic [PAY_W-1:0] pay_d;
  logic [PAY_W-1:0] pay_q;

  pf_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign policy = pf_policy_e'({mode_data_only, mode_instr_only});

  pf_decide u_decide (
    .is_instr (req_is_instr),
    .l2_hit   (req_l2_hit),
    .policy   (policy),
    .action   (action_d)
  );

  assign pay_d = {req_tag, req_is_write, action_d};

  pf_pipe_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (rst_sync_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_d),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (pay_q)
  );

  assign action_q     = pay_q[PF_ACTION_W-1:0];
  assign rsp_write    = pay_q[PF_ACTION_W];
  assign rsp_tag      = pay_q[PAY_W-1 -: TAG_W];
  assign rsp_use_l2   = action_q.use_l2;
  assign rsp_allocate = action_q.allocate;
  assign rsp_bypass   = action_q.bypass;
endmodule

// File: rtl/pf_alloc_filter_chk.sv
module pf_alloc_filter_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_instr_only,
  input logic             mode_data_only,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_is_instr,
  input logic             req_l2_hit,
  input logic [TAG_W-1:0] req_tag,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_use_l2,
  input logic             rsp_allocate,
  input logic             rsp_bypass,
  input logic [TAG_W-1:0] rsp_tag
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R1
  hit_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_l2_hit) |=> (rsp_use_l2 && !rsp_allocate && !rsp_bypass));

  // R2
  data_miss_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_l2_hit && !req_is_instr && mode_instr_only) |=> (rsp_bypass && !rsp_allocate));

  // R3
  instr_miss_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_l2_hit && req_is_instr && mode_data_only) |=> (rsp_bypass && !rsp_allocate));

  // R5
  open_miss_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_l2_hit && !mode_instr_only && !mode_data_only) |=> (rsp_use_l2 && rsp_allocate));

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_use_l2, rsp_bypass}));

  // R6
  alloc_with_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_allocate) |-> rsp_use_l2);

  // R7
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (rsp_valid && rsp_tag == $past(req_tag)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_use_l2)
                                   && $stable(rsp_allocate) && $stable(rsp_bypass)));
endmodule

bind pf_alloc_filter pf_alloc_filter_chk #(.TAG_W(TAG_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_instr_only (mode_instr_only),
  .mode_data_only  (mode_data_only),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_is_instr    (req_is_instr),
  .req_l2_hit      (req_l2_hit),
  .req_tag         (req_tag),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_use_l2      (rsp_use_l2),
  .rsp_allocate    (rsp_allocate),
  .rsp_bypass      (rsp_bypass),
  .rsp_tag         (rsp_tag)
);

// File: tb/pf_alloc_filter_test.sv
module pf_alloc_filter_test;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_instr_only = 1'b0, mode_data_only = 1'b0;
  logic req_valid = 1'b0, req_is_instr = 1'b0, req_is_write = 1'b0, req_l2_hit = 1'b0;
  logic [TAG_W-1:0] req_tag = '0;
  logic rsp_ready = 1'b0;
  logic req_ready, rsp_valid, rsp_use_l2, rsp_allocate, rsp_bypass, rsp_write;
  logic [TAG_W-1:0] rsp_tag;

  int unsigned checks = 0, errors = 0;

  // model state
  logic       m_valid = 1'b0;
  logic [2:0] m_act = '0;
  logic       m_write = 1'b0;
  logic [TAG_W-1:0] m_tag = '0;
  string      m_rule = "R5";

  always #2 clk = ~clk;

  pf_alloc_filter #(.TAG_W(TAG_W)) uut (.*);

  // {use_l2, allocate, bypass}
  function automatic logic [2:0] expect_act(logic instr, logic hit, logic io, logic dO);
    if (hit) return 3'b100;
    if ((io && !instr) || (dO && instr)) return 3'b001;
    return 3'b110;
  endfunction

  function automatic string rule_of(logic instr, logic hit, logic io, logic dO);
    if (hit) return "R1";
    if (io && dO) return "R4";
    if (io && !instr) return "R2";
    if (dO && instr) return "R3";
    return "R5";
  endfunction

  task automatic check(string rule, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rule, act, exp);
    end
  endtask

  // Called at a falling edge: check held outputs, drive inputs, update model.
  task automatic step(logic v, logic instr, logic wr, logic hit, logic [TAG_W-1:0] tag,
                      logic io, logic dO, logic rr);
    check("R7", {31'd0, rsp_valid}, {31'd0, m_valid});
    if (m_valid) begin
      check(m_rule, {29'd0, rsp_use_l2, rsp_allocate, rsp_bypass}, {29'd0, m_act});
      check("R7", {23'd0, rsp_write, rsp_tag}, {23'd0, m_write, m_tag});
      check("R6", {31'd0, (rsp_use_l2 ^ rsp_bypass) && (!rsp_allocate || rsp_use_l2)}, 32'd1);
    end
    req_valid = v; req_is_instr = instr; req_is_write = wr; req_l2_hit = hit;
    req_tag = tag; mode_instr_only = io; mode_data_only = dO; rsp_ready = rr;
    #1;
    check("R8", {31'd0, req_ready}, {31'd0, !m_valid || rr});
    if (m_valid && rr) m_valid = 1'b0;
    if (v && req_ready) begin
      m_valid = 1'b1;
      m_act   = expect_act(instr, hit, io, dO);
      m_rule  = rule_of(instr, hit, io, dO);
      m_write = wr;
      m_tag   = tag;
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    req_valid = 1'b1;
    @(negedge clk); #1;
    check("R10", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    // Directed sweep: every policy x class x direction x hit/miss (R1..R5)
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++)
        step(1'b1, k[0], k[1], k[2], TAG_W'(p*8+k), p[0], p[1], 1'b1);
    step(1'b0, 0, 0, 0, '0, 0, 0, 1'b1);

    // R4: locked cache, write hit still served, write miss bypassed
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'hA1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'hA2, 1'b1, 1'b1, 1'b1);
    step(1'b0, 0, 0, 0, '0, 1, 1, 1'b1);

    // R9: open-policy miss accepted, then stalled while policy locks
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h56, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h56, 1'b1, 1'b1, 1'b0);
    check("R9", {31'd0, rsp_allocate}, 32'd1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h56, 1'b1, 1'b1, 1'b1);
    check("R9", {31'd0, rsp_bypass}, 32'd1);
    step(1'b0, 0, 0, 0, '0, 0, 0, 1'b1);

    // Random traffic with back-pressure and policy changes
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[0] | r[1], r[2], r[3], r[4], TAG_W'($urandom),
           ($urandom % 5) == 0, ($urandom % 5) == 1, r[5] | r[6]);
    end
    step(1'b0, 0, 0, 0, '0, 0, 0, 1'b1);
    step(1'b0, 0, 0, 0, '0, 0, 0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule